// File: doc/BRIEF.md
# Microcoded Sequencer with Opcode Dispatch

This block is the control unit of a small accumulator machine. It steps through a microcode store of 128 words, each 13 bits wide, and executes one microword per clock. A microword names one control line, gives the level to drive on it, and gives the address of the next microword. The sequencer keeps every control line in its own register. A line holds its level until a later microword changes it, and all lines go to the datapath together as one vector.

Two control lines also steer the sequencer. When the line that requests instruction decode is raised, the next microaddress comes from the routine entry chosen by the 3-bit opcode and the datapath's zero and minus flags. The next-address field of the microword is not used. When the line that ends an instruction is raised, the sequencer goes back to the fetch routine's entry. A halt code sets a halt register. From then on the sequencer is frozen and `done` is high.

The microcode is written through a load port. The routine entry addresses are inputs, supplied along with the microcode.

Top module: `microseq`

## Requirements
- R1: While `rst` is high at a clock edge, all control lines are cleared, `done` is cleared, and `upc` takes the value of `ent_fetch`.
- R2: A microword is laid out as signal code in bits 12:8, level in bit 7 and next address in bits 6:0. When the code is 0 to 16, control line `ctrl[code]` takes the level at the next edge, and every other line keeps its value.
- R3: Codes 17 to 30 change no control line and do not set `done`.
- R4: Exactly one microword executes per clock. Unless R5, R6 or R7 applies, `upc` becomes bits 6:0 of the microword just executed. This also covers code 15 or 16 with level 0.
- R5: For code 15 with level 1, the next `upc` is chosen by opcode: 000 gives `ent_store`, 001 `ent_load`, 010 `ent_add`, 011 `ent_sub`, 100 `ent_jump` and 111 `ent_stop`.
- R6: For code 15 with level 1, opcode 101 goes to `ent_jump` when `zero_flag` is 1 and to `ent_fetch` otherwise. Opcode 110 goes to `ent_jump` when `minus_flag` is 1 and to `ent_fetch` otherwise.
- R7: For code 16 with level 1, the next `upc` is `ent_fetch`.
- R8: Code 31 loads its level into the halt register, and `done` shows that register. With level 1, `done` rises at the next edge and `upc` moves to bits 6:0. After that, `upc`, `ctrl` and `done` hold until reset. With level 0, `done` stays low and sequencing continues.
- R9: While `load_en` is high, `load_word` is written at `load_addr` and sequencing pauses: `upc`, `ctrl` and `done` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Microcode write strobe; pauses sequencing |
| load_addr | input | 7 | Microcode write address |
| load_word | input | 13 | Microcode write data |
| ent_fetch | input | 7 | Fetch routine entry |
| ent_store | input | 7 | Store routine entry |
| ent_load | input | 7 | Load routine entry |
| ent_add | input | 7 | Add routine entry |
| ent_sub | input | 7 | Subtract routine entry |
| ent_jump | input | 7 | Jump routine entry |
| ent_stop | input | 7 | Halt routine entry |
| opcode | input | 3 | Opcode bits from the instruction register |
| zero_flag | input | 1 | Accumulator is zero |
| minus_flag | input | 1 | Accumulator is negative |
| ctrl | output | 17 | Registered control line levels, indexed by signal code |
| upc | output | 7 | Current microaddress |
| done | output | 1 | Halt register |

## Verification
The bench goes through all eight opcodes with both values of each flag, so that every dispatch entry and every conditional fall-back is observed. A design with a swapped flag or a missing fall-back would land on the wrong entry. It also runs decode and cycle codes with level 0. A sequencer that reacted to the code without looking at the level would jump when it should follow the next field.

Halt is checked with level 1 and level 0, and the microaddress and control lines are then held across many further clocks. A design that decoded only the code would freeze on a clearing word, and one that kept stepping after halt would change them. Random microcode full of unused codes and interleaved load writes shows that no-op codes leave the control lines alone and that a write stalls the machine for exactly that cycle.

// File: rtl/microseq.sv
module microseq #(
  parameter int AW    = 7,
  parameter int SW    = 5,
  parameter int NCTRL = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [AW-1:0]    load_addr,
  input  logic [SW+AW:0]   load_word,
  input  logic [AW-1:0]    ent_fetch,
  input  logic [AW-1:0]    ent_store,
  input  logic [AW-1:0]    ent_load,
  input  logic [AW-1:0]    ent_add,
  input  logic [AW-1:0]    ent_sub,
  input  logic [AW-1:0]    ent_jump,
  input  logic [AW-1:0]    ent_stop,
  input  logic [2:0]       opcode,
  input  logic             zero_flag,
  input  logic             minus_flag,
  output logic [NCTRL-1:0] ctrl,
  output logic [AW-1:0]    upc,
  output logic             done
);
  localparam int WW       = SW + AW + 1;
  localparam int DEPTH    = 1 << AW;
  localparam int DECODE_C = NCTRL - 2;
  localparam int CYCLE_C  = NCTRL - 1;
  localparam int HALT_C   = (1 << SW) - 1;

  logic [WW-1:0] store [DEPTH];
  logic [WW-1:0] w;
  logic [SW-1:0] sig;
  logic          lvl;
  logic [AW-1:0] nxt;
  logic [AW-1:0] disp;
  logic [AW-1:0] upc_d;
  logic          halt_q;
  logic          step;

  assign w    = store[upc];
  assign sig  = w[WW-1 -: SW];
  assign lvl  = w[AW];
  assign nxt  = w[AW-1:0];
  assign step = !load_en && !halt_q;
  assign done = halt_q;

  always_ff @(posedge clk)
    if (load_en) store[load_addr] <= load_word;

  always_comb begin
    case (opcode)
      3'b000:  disp = ent_store;
      3'b001:  disp = ent_load;
      3'b010:  disp = ent_add;
      3'b011:  disp = ent_sub;
      3'b100:  disp = ent_jump;
      3'b101:  disp = zero_flag  ? ent_jump : ent_fetch;
      3'b110:  disp = minus_flag ? ent_jump : ent_fetch;
      default: disp = ent_stop;
    endcase
  end

  always_comb begin
    if (lvl && sig == SW'(DECODE_C))     upc_d = disp;
    else if (lvl && sig == SW'(CYCLE_C)) upc_d = ent_fetch;
    else                                 upc_d = nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upc    <= ent_fetch;
      halt_q <= 1'b0;
    end else if (step) begin
      upc <= upc_d;
      if (sig == SW'(HALT_C)) halt_q <= lvl;
    end
  end

  for (genvar i = 0; i < NCTRL; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)                             ctrl[i] <= 1'b0;
      else if (step && sig == SW'(i))      ctrl[i] <= lvl;
    end
  end
endmodule

module microseq_chk #(
  parameter int AW    = 7,
  parameter int SW    = 5,
  parameter int NCTRL = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [SW-1:0]    sig,
  input logic             lvl,
  input logic [AW-1:0]    ent_fetch,
  input logic [NCTRL-1:0] ctrl,
  input logic [AW-1:0]    upc,
  input logic             done
);
  localparam int CYCLE_C = NCTRL - 1;
  localparam int HALT_C  = (1 << SW) - 1;

  logic go;
  assign go = !load_en && !done;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctrl == '0 && !done && upc == $past(ent_fetch)));

  assert_line_level_R2: assert property (@(posedge clk) disable iff (rst)
    (go && sig < SW'(NCTRL)) |=> ctrl[$past(sig)] == $past(lvl));

  assert_noop_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (go && sig >= SW'(NCTRL) && sig != SW'(HALT_C)) |=> ($stable(ctrl) && !done));

  assert_cycle_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    (go && lvl && sig == SW'(CYCLE_C)) |=> upc == $past(ent_fetch));

  assert_halt_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (go && lvl && sig == SW'(HALT_C)) |=> done);

  assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(upc) && $stable(ctrl)));

  assert_load_pause_R9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> ($stable(upc) && $stable(ctrl) && $stable(done)));
endmodule

bind microseq microseq_chk #(.AW(AW), .SW(SW), .NCTRL(NCTRL)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .sig(sig), .lvl(lvl),
  .ent_fetch(ent_fetch), .ctrl(ctrl), .upc(upc), .done(done)
);

// File: tb/microseq_test.sv
module microseq_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        load_en = 0;
  logic [6:0]  load_addr = 0;
  logic [12:0] load_word = 0;
  logic [6:0]  ent_fetch = 0, ent_store = 20, ent_load = 30, ent_add = 40,
               ent_sub = 50, ent_jump = 60, ent_stop = 70;
  logic [2:0]  opcode = 0;
  logic        zero_flag = 0, minus_flag = 0;
  logic [16:0] ctrl;
  logic [6:0]  upc;
  logic        done;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [12:0] m_mem [128];
  logic [6:0]  m_upc;
  logic [16:0] m_ctrl;
  logic        m_done;

  always #5 clk = ~clk;

  microseq uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_word(load_word), .ent_fetch(ent_fetch), .ent_store(ent_store),
    .ent_load(ent_load), .ent_add(ent_add), .ent_sub(ent_sub),
    .ent_jump(ent_jump), .ent_stop(ent_stop), .opcode(opcode),
    .zero_flag(zero_flag), .minus_flag(minus_flag),
    .ctrl(ctrl), .upc(upc), .done(done)
  );

  function automatic logic [12:0] mw(input int code, input bit l, input int nx);
    return {5'(code), l, 7'(nx)};
  endfunction

  function automatic logic [6:0] exp_dispatch();
    case (opcode)
      3'd0: return ent_store;
      3'd1: return ent_load;
      3'd2: return ent_add;
      3'd3: return ent_sub;
      3'd4: return ent_jump;
      3'd5: return zero_flag  ? ent_jump : ent_fetch;
      3'd6: return minus_flag ? ent_jump : ent_fetch;
      default: return ent_stop;
    endcase
  endfunction

  task automatic compare(input string tag);
    total++;
    if (upc !== m_upc || ctrl !== m_ctrl || done !== m_done) begin
      bad++;
      $display("FAIL %s: upc=%0d ctrl=%h done=%b expected upc=%0d ctrl=%h done=%b",
               tag, upc, ctrl, done, m_upc, m_ctrl, m_done);
    end
  endtask

  task automatic do_reset(input logic [6:0] f);
    rst = 1; ent_fetch = f;
    @(posedge clk); @(negedge clk);
    rst = 0;
    m_upc = f; m_ctrl = '0; m_done = 0;
    compare("R1 reset");
  endtask

  task automatic write_word(input logic [6:0] a, input logic [12:0] d, input bit chk);
    load_en = 1; load_addr = a; load_word = d;
    m_mem[a] = d;
    @(posedge clk); @(negedge clk);
    load_en = 0;
    if (chk) compare("R9 load pause");
  endtask

  task automatic step(input string force_tag);
    logic [12:0] w;
    logic [4:0]  s;
    logic        l;
    string       tag;
    w = m_mem[m_upc]; s = w[12:8]; l = w[7];
    tag = "R4 next field";
    if (m_done) tag = "R8 frozen";
    else begin
      if (s <= 16) begin m_ctrl[s] = l; tag = "R2 line level"; end
      else if (s == 31) begin m_done = l; tag = "R8 halt code"; end
      else tag = "R3 noop code";
      if (s == 15 && l) begin
        m_upc = exp_dispatch();
        tag = (opcode == 5 || opcode == 6) ? "R6 cond dispatch" : "R5 dispatch";
      end else if (s == 16 && l) begin
        m_upc = ent_fetch; tag = "R7 cycle";
      end else m_upc = w[6:0];
    end
    if (force_tag != "") tag = force_tag;
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    for (int a = 0; a < 128; a++) begin
      logic [12:0] r;
      r = 13'($urandom());
      if (r[12:8] == 5'd31) r[7] = 1'b0;
      write_word(7'(a), r, 0);
    end
    do_reset(7'd0);

    for (int n = 0; n < 400; n++) begin
      opcode = 3'($urandom()); zero_flag = 1'($urandom()); minus_flag = 1'($urandom());
      if (n % 37 == 36) write_word(7'($urandom()), mw(int'($urandom() % 31), 1'($urandom()), int'($urandom() % 128)), 1);
      else step("");
    end

    // R5 R6: all opcodes and flag combinations
    write_word(7'd0, mw(15, 1, 3), 0);
    for (int op = 0; op < 8; op++)
      for (int f = 0; f < 4; f++) begin
        do_reset(7'd0);
        opcode = 3'(op); zero_flag = f[0]; minus_flag = f[1];
        step((op == 5 || op == 6) ? "R6 cond dispatch" : "R5 dispatch");
      end

    // R4: decode and cycle at level 0 follow the next field
    write_word(7'd0, mw(15, 0, 11), 0);
    write_word(7'd11, mw(16, 0, 12), 0);
    write_word(7'd12, mw(16, 1, 99), 0);
    do_reset(7'd0);
    opcode = 3'd4;
    step("R4 decode low");
    step("R4 cycle low");
    step("R7 cycle");

    // R3: no-op codes keep lines
    write_word(7'd0, mw(3, 1, 1), 0);
    write_word(7'd1, mw(17, 1, 2), 0);
    write_word(7'd2, mw(30, 0, 3), 0);
    write_word(7'd3, mw(24, 1, 0), 0);
    do_reset(7'd0);
    for (int k = 0; k < 4; k++) step("");

    // R8: halt level 0 keeps running
    write_word(7'd0, mw(31, 0, 9), 0);
    write_word(7'd9, mw(8, 1, 10), 0);
    write_word(7'd10, mw(31, 1, 33), 0);
    write_word(7'd33, mw(5, 1, 34), 0);
    do_reset(7'd0);
    step("R8 halt low");
    step("R2 after halt low");
    step("R8 halt high");
    for (int k = 0; k < 6; k++) step("R8 frozen");
    write_word(7'd33, mw(16, 1, 0), 1);
    step("R8 frozen after load");

    do_reset(7'd5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule